// File: doc/BRIEF.md
# Manchester word receiver

This block receives one serial word in Manchester code and turns it back into NRZ data. The line can come in as a complementary pair, with one wire high for the positive state and the other high for the negative state. It can also come in as a single wire, with the pair held at fixed levels. The receiver runs on a clock at twelve times the bit rate. It looks for the sync character that opens each word. It decides from the sync whether the word is a command or a data word. It then decodes sixteen data bits and a parity bit.

The recovered shift clock is the oversampling clock divided by twelve. Its phase is pulled onto the incoming transitions, so a downstream register can capture the data on its rising edge. The word is presented through four signals:
- the serial data,
- a window that marks the data bits,
- a flag that tells a command word from a data word,
- a one-period pulse that qualifies the whole word.

A word-reset input drops the current word and returns the receiver to hunting for sync.

Top module: `manchester_word_rx`

## Requirements
- R1: The line level is high when `one_i` is high and `zero_i` is low, or when `uni_i` is high. In single-wire use `one_i` is held low and `zero_i` high, so `uni_i` alone carries the level. In pair use `uni_i` is held low.
- R2: `shift_clk_o` has a period of 12 clocks and is high for 6 of them while no transitions arrive. A mid-cell transition that lands up to 2 clocks away from its nominal point re-aligns the phase. That cell then lasts 14 or 10 clocks instead of 12.
- R3: A sync is a level held for 15 to 21 clocks followed by the opposite level. If the first part is high the word is a command word; if low, a data word. A first part of 24 clocks is not taken as a sync.
- R4: A cell that is high and then low carries a 1; low and then high carries a 0. Sixteen data bits follow the sync, most significant first, then one parity bit.
- R5: While `take_o` is high, the rising edges of `shift_clk_o` present data bits 15 down to 0 on `sdo_o`, one bit per edge, 16 edges in all.
- R6: `take_o` rises with a shift-clock rising edge, only when the first two data cells both had a mid-cell transition. It then stays high for 16 shift-clock periods (192 clocks when there is no jitter).
- R7: `cmd_sync_o` is high exactly while `take_o` is high and the word opened with a command sync. Otherwise it is low.
- R8: A cell whose samples at its quarter and three-quarter points are equal is a coding error. A word with a coding error never raises `valid_o`.
- R9: `valid_o` is high for exactly 12 clocks, starting with the shift-clock rising edge after the parity cell. It is raised only when there was no coding error and the 17 bits (data and parity) hold an odd number of ones.
- R10: If `word_rst_i` is high in the cycle where `shift_clk_o` rises, `take_o` and `valid_o` drop and the receiver hunts for a new sync.
- R11: While `rst_ni` is low, `take_o`, `valid_o`, `cmd_sync_o` and `sdo_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock, 12x the bit rate |
| rst_ni | input | 1 | Asynchronous active-low master reset |
| one_i | input | 1 | Pair input, high for the positive line state |
| zero_i | input | 1 | Pair input, high for the negative line state |
| uni_i | input | 1 | Single-wire line input |
| word_rst_i | input | 1 | Abandon the current word, sampled when the shift clock rises |
| sdo_o | output | 1 | Decoded NRZ serial data |
| shift_clk_o | output | 1 | Recovered bit clock |
| take_o | output | 1 | Data window |
| cmd_sync_o | output | 1 | Command-word flag |
| valid_o | output | 1 | Word qualified by parity and coding |

## Verification
The assertions assume that the line changes only at Manchester cell boundaries and mid-cell points. Mid-cell jitter stays within two clocks and never affects two neighbouring cells. Before each sync, the line rests for more than 21 clocks at the level opposite the first half of the sync. The stimulus meets these conditions as follows:
- Every word starts with a 36-clock rest at the opposite level.
- Jitter is applied only to cells 3 and 9.
- `word_rst_i` is held for a whole shift-clock period.
- There are 60 quiet clocks after each word, so the qualifying pulse finishes before the next sync begins.

// File: rtl/mwr_pkg.sv
package mwr_pkg;
  typedef enum logic [1:0] {
    ST_HUNT,
    ST_SYNC,
    ST_DATA,
    ST_DONE
  } rx_state_e;
endpackage

// File: rtl/mwr_line_in.sv
module mwr_line_in #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic one_i,
  input  logic zero_i,
  input  logic uni_i,
  output logic lvl_o,
  output logic prev_o,
  output logic edge_o
);
  logic raw;
  logic [SYNC_STAGES:0] chain_q;

  // pair mode: one high / zero low; single-wire mode: pair parked, uni carries level
  assign raw = (one_i & ~zero_i) | uni_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[SYNC_STAGES-1:0], raw};
  end

  assign lvl_o  = chain_q[SYNC_STAGES-1];
  assign prev_o = chain_q[SYNC_STAGES];
  assign edge_o = lvl_o ^ prev_o;
endmodule

// File: rtl/mwr_phase.sv
module mwr_phase #(
  parameter int OVS      = 12,
  parameter int EDGE_TOL = 2,
  parameter int PH_W     = 4,
  parameter int RUN_W    = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             edge_i,
  input  logic             align_i,
  input  logic             track_i,
  output logic [PH_W-1:0]  ph_o,
  output logic [RUN_W-1:0] run_o,
  output logic             shift_clk_o
);
  localparam int HALF = OVS / 2;
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(OVS - 1);
  localparam logic [PH_W-1:0]  PH_SET  = PH_W'(HALF + 1);
  localparam logic [PH_W-1:0]  PH_HALF = PH_W'(HALF);
  localparam logic [PH_W-1:0]  WIN_LO  = PH_W'(HALF - EDGE_TOL);
  localparam logic [PH_W-1:0]  WIN_HI  = PH_W'(HALF + EDGE_TOL);
  localparam logic [RUN_W-1:0] RUN_SAT = '1;

  logic [PH_W-1:0]  ph_q;
  logic [RUN_W-1:0] run_q;
  logic             in_win;

  assign in_win = (ph_q >= WIN_LO) && (ph_q <= WIN_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= '0;
      run_q <= RUN_SAT;
    end else begin
      // a mid-cell edge is taken as nominal HALF, so the next phase is HALF+1
      if (align_i || (track_i && edge_i && in_win)) ph_q <= PH_SET;
      else if (ph_q == PH_LAST)                      ph_q <= '0;
      else                                           ph_q <= ph_q + 1'b1;

      if (edge_i)                 run_q <= RUN_W'(1);
      else if (run_q != RUN_SAT)  run_q <= run_q + 1'b1;
    end
  end

  assign ph_o        = ph_q;
  assign run_o       = run_q;
  assign shift_clk_o = ph_q < PH_HALF;

  p_ph_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q <= PH_LAST);
endmodule

// File: rtl/mwr_word_fsm.sv
module mwr_word_fsm
  import mwr_pkg::*;
#(
  parameter int OVS       = 12,
  parameter int DATA_BITS = 16,
  parameter int SYNC_TOL  = 3,
  parameter int PH_W      = 4,
  parameter int RUN_W     = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lvl_i,
  input  logic             prev_i,
  input  logic             edge_i,
  input  logic             word_rst_i,
  input  logic [PH_W-1:0]  ph_i,
  input  logic [RUN_W-1:0] run_i,
  output logic             align_o,
  output logic             track_o,
  output logic             sdo_o,
  output logic             take_o,
  output logic             cmd_sync_o,
  output logic             valid_o
);
  localparam int HALF     = OVS / 2;
  localparam int SYNC_LEN = OVS + HALF;
  localparam int CNT_W    = $clog2(DATA_BITS + 2);
  localparam logic [RUN_W-1:0] RUN_MIN  = RUN_W'(SYNC_LEN - SYNC_TOL);
  localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(SYNC_LEN + SYNC_TOL);
  localparam logic [RUN_W-1:0] RUN_HALF = RUN_W'(HALF);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(OVS - 1);
  localparam logic [PH_W-1:0]  PH_A     = PH_W'(OVS / 4);
  localparam logic [PH_W-1:0]  PH_B     = PH_W'(HALF + OVS / 4);
  localparam logic [CNT_W-1:0] CNT_TAKE = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_PAR  = CNT_W'(DATA_BITS);

  rx_state_e        state_q;
  logic [CNT_W-1:0] bcnt_q;
  logic             samp_q, pend_q, sdo_q, par_q, err_q;
  logic             take_q, cmd_q, valid_q;
  logic             rise, wrst;

  assign rise    = (ph_i == '0);
  assign wrst    = rise && word_rst_i;
  assign align_o = (state_q == ST_HUNT) && !wrst && edge_i &&
                   (run_i >= RUN_MIN) && (run_i <= RUN_MAX);
  assign track_o = (state_q == ST_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HUNT;
      bcnt_q  <= '0;
      samp_q  <= 1'b0;
      pend_q  <= 1'b0;
      sdo_q   <= 1'b0;
      par_q   <= 1'b0;
      err_q   <= 1'b0;
      take_q  <= 1'b0;
      cmd_q   <= 1'b0;
      valid_q <= 1'b0;
    end else if (wrst) begin
      state_q <= ST_HUNT;
      take_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_HUNT: if (align_o) begin
          state_q <= ST_SYNC;
          cmd_q   <= prev_i;  // level of the first sync half
          err_q   <= 1'b0;
          par_q   <= 1'b0;
          bcnt_q  <= '0;
        end
        ST_SYNC: begin
          if (edge_i)                                   state_q <= ST_HUNT;
          else if (ph_i == PH_LAST && run_i > RUN_HALF) state_q <= ST_DATA;
        end
        ST_DATA: begin
          if (ph_i == PH_A) samp_q <= lvl_i;
          if (ph_i == PH_B) begin
            if (lvl_i == samp_q) err_q <= 1'b1;
            par_q  <= par_q ^ samp_q;
            sdo_q  <= pend_q;   // two-cell delay so the window edges carry bits 0..15
            pend_q <= samp_q;
          end
          if (ph_i == PH_LAST) begin
            bcnt_q <= bcnt_q + 1'b1;
            if (bcnt_q == CNT_TAKE && !err_q) take_q <= 1'b1;
            if (bcnt_q == CNT_PAR) begin
              state_q <= ST_DONE;
              valid_q <= !err_q && par_q;
            end
          end
        end
        ST_DONE: if (ph_i == PH_LAST) begin
          state_q <= ST_HUNT;
          take_q  <= 1'b0;
          valid_q <= 1'b0;
        end
        default: state_q <= ST_HUNT;
      endcase
    end
  end

  assign sdo_o      = sdo_q;
  assign take_o     = take_q;
  assign cmd_sync_o = take_q & cmd_q;
  assign valid_o    = valid_q;

  p_valid_in_take_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> take_q);
  p_valid_on_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) |-> (ph_i == '0));
  p_take_on_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(take_q) |-> (ph_i == '0));
  p_cmd_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_q && $past(take_q)) |-> $stable(cmd_q));
  p_data_entry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && $past(state_q) == ST_SYNC) |-> (ph_i == '0));
  p_word_rst_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && word_rst_i) |=> (!take_q && !valid_q));
endmodule

// File: rtl/manchester_word_rx.sv
module manchester_word_rx #(
  parameter int OVS         = 12,
  parameter int DATA_BITS   = 16,
  parameter int SYNC_TOL    = 3,
  parameter int EDGE_TOL    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic one_i,
  input  logic zero_i,
  input  logic uni_i,
  input  logic word_rst_i,
  output logic sdo_o,
  output logic shift_clk_o,
  output logic take_o,
  output logic cmd_sync_o,
  output logic valid_o
);
  localparam int PH_W  = $clog2(OVS);
  localparam int RUN_W = $clog2(OVS + OVS / 2 + SYNC_TOL + 2);

  logic             lvl, prev, edge_det, align, track;
  logic [PH_W-1:0]  ph;
  logic [RUN_W-1:0] run;

  mwr_line_in #(.SYNC_STAGES(SYNC_STAGES)) u_line (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .one_i  (one_i),
    .zero_i (zero_i),
    .uni_i  (uni_i),
    .lvl_o  (lvl),
    .prev_o (prev),
    .edge_o (edge_det)
  );

  mwr_phase #(.OVS(OVS), .EDGE_TOL(EDGE_TOL), .PH_W(PH_W), .RUN_W(RUN_W)) u_phase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .edge_i      (edge_det),
    .align_i     (align),
    .track_i     (track),
    .ph_o        (ph),
    .run_o       (run),
    .shift_clk_o (shift_clk_o)
  );

  mwr_word_fsm #(.OVS(OVS), .DATA_BITS(DATA_BITS), .SYNC_TOL(SYNC_TOL),
                 .PH_W(PH_W), .RUN_W(RUN_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lvl_i      (lvl),
    .prev_i     (prev),
    .edge_i     (edge_det),
    .word_rst_i (word_rst_i),
    .ph_i       (ph),
    .run_i      (run),
    .align_o    (align),
    .track_o    (track),
    .sdo_o      (sdo_o),
    .take_o     (take_o),
    .cmd_sync_o (cmd_sync_o),
    .valid_o    (valid_o)
  );
endmodule

// File: tb/manchester_word_rx_tb_top.sv
`timescale 1ns/1ps
module manchester_word_rx_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic one_i = 1'b0, zero_i = 1'b1, uni_i = 1'b0, word_rst_i = 1'b0;
  logic sdo_o, shift_clk_o, take_o, cmd_sync_o, valid_o;

  always #10 clk = ~clk;

  manchester_word_rx dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .one_i       (one_i),
    .zero_i      (zero_i),
    .uni_i       (uni_i),
    .word_rst_i  (word_rst_i),
    .sdo_o       (sdo_o),
    .shift_clk_o (shift_clk_o),
    .take_o      (take_o),
    .cmd_sync_o  (cmd_sync_o),
    .valid_o     (valid_o)
  );

  int checks = 0, errors = 0;
  bit uni_mode = 1'b0;

  logic [15:0] got;
  int n_bits, take_cyc, valid_cyc, cmd_bad, min_iv, max_iv;
  bit take_end;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_lvl(input bit l);
    if (uni_mode) begin one_i = 1'b0; zero_i = 1'b1; uni_i = l; end
    else          begin one_i = l;    zero_i = ~l;   uni_i = 1'b0; end
  endtask

  task automatic hold(input bit l, input int n);
    set_lvl(l);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_word(input bit cmd, input logic [15:0] d, input bit par_ok,
                            input int bad_bit, input bit jit, input int first_len);
    bit p;
    p = (~^d) ^ !par_ok;
    hold(~cmd, 36);
    hold(cmd, first_len);
    hold(~cmd, 18);
    for (int i = 0; i < 17; i++) begin
      bit b;
      int j;
      b = (i < 16) ? d[15-i] : p;
      j = 0;
      if (jit && i == 3) j = 2;
      if (jit && i == 9) j = -2;
      hold(b, 6 + j);
      hold((i == bad_bit) ? b : ~b, 6 - j);
    end
    repeat (60) @(negedge clk);
  endtask

  task automatic monitor(input int n, input bit exp_cmd);
    bit prev_sc;
    int last_rise;
    got = '0; n_bits = 0; take_cyc = 0; valid_cyc = 0; cmd_bad = 0;
    min_iv = 1000; max_iv = 0; last_rise = -1;
    prev_sc = shift_clk_o;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      if (shift_clk_o && !prev_sc && take_o) begin
        got = {got[14:0], sdo_o};
        n_bits++;
        if (last_rise >= 0) begin
          if (c - last_rise < min_iv) min_iv = c - last_rise;
          if (c - last_rise > max_iv) max_iv = c - last_rise;
        end
        last_rise = c;
      end
      prev_sc = shift_clk_o;
      if (take_o) take_cyc++;
      if (valid_o) valid_cyc++;
      if (cmd_sync_o != (take_o & exp_cmd)) cmd_bad++;
    end
    take_end = take_o;
  endtask

  task automatic run_word(input bit cmd, input logic [15:0] d, input bit par_ok,
                          input int bad_bit, input bit jit, input int first_len,
                          input int rst_at);
    int n;
    n = 36 + first_len + 18 + 204 + 60;
    fork
      drive_word(cmd, d, par_ok, bad_bit, jit, first_len);
      monitor(n, cmd);
      begin
        if (rst_at > 0) begin
          repeat (rst_at) @(negedge clk);
          word_rst_i = 1'b1;
          repeat (12) @(negedge clk);
          word_rst_i = 1'b0;
        end
      end
    join
  endtask

  task automatic t_reset;
    set_lvl(1'b0);
    repeat (5) @(negedge clk);
    chk(take_o == 1'b0 && valid_o == 1'b0, "R11", "take/valid in reset", {take_o, valid_o}, 0);
    chk(cmd_sync_o == 1'b0 && sdo_o == 1'b0, "R11", "cmd/sdo in reset", {cmd_sync_o, sdo_o}, 0);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  task automatic t_shift_idle;
    int per, hi;
    bit prev;
    prev = shift_clk_o;
    while (!(shift_clk_o && !prev)) begin prev = shift_clk_o; @(negedge clk); end
    per = 0; hi = 0; prev = shift_clk_o;
    do begin
      if (shift_clk_o) hi++;
      per++;
      prev = shift_clk_o;
      @(negedge clk);
    end while (!(shift_clk_o && !prev));
    chk(per == 12, "R2", "idle shift clock period", per, 12);
    chk(hi == 6, "R2", "idle shift clock high time", hi, 6);
  endtask

  task automatic t_cmd_pair;
    run_word(1'b1, 16'hA5C3, 1'b1, -1, 1'b0, 18, 0);
    chk(got == 16'hA5C3, "R4", "command word data", int'(got), 'hA5C3);
    chk(n_bits == 16, "R5", "bits in window", n_bits, 16);
    chk(take_cyc == 192, "R6", "take length", take_cyc, 192);
    chk(cmd_bad == 0, "R7", "command flag mismatches", cmd_bad, 0);
    chk(valid_cyc == 12, "R9", "valid length", valid_cyc, 12);
    chk(min_iv == 12 && max_iv == 12, "R2", "shift period in word", max_iv, 12);
  endtask

  task automatic t_data_sync;
    run_word(1'b0, 16'h1234, 1'b1, -1, 1'b0, 18, 0);
    chk(got == 16'h1234, "R3", "data word data", int'(got), 'h1234);
    chk(take_cyc == 192 && cmd_bad == 0, "R7", "data sync flag low", cmd_bad, 0);
    chk(valid_cyc == 12, "R9", "data word valid", valid_cyc, 12);
  endtask

  task automatic t_single_wire;
    uni_mode = 1'b1;
    run_word(1'b1, 16'h0F0F, 1'b1, -1, 1'b0, 18, 0);
    uni_mode = 1'b0;
    chk(got == 16'h0F0F && n_bits == 16, "R1", "single-wire data", int'(got), 'h0F0F);
    chk(valid_cyc == 12 && cmd_bad == 0, "R1", "single-wire valid", valid_cyc, 12);
  endtask

  task automatic t_code_err;
    run_word(1'b1, 16'h6B2D, 1'b1, 7, 1'b0, 18, 0);
    chk(take_cyc == 192, "R8", "take after late coding error", take_cyc, 192);
    chk(valid_cyc == 0, "R8", "valid after coding error", valid_cyc, 0);
  endtask

  task automatic t_early_err;
    run_word(1'b0, 16'h4E71, 1'b1, 1, 1'b0, 18, 0);
    chk(take_cyc == 0, "R6", "take after early coding error", take_cyc, 0);
    chk(valid_cyc == 0, "R8", "valid after early coding error", valid_cyc, 0);
  endtask

  task automatic t_parity;
    run_word(1'b1, 16'h8001, 1'b0, -1, 1'b0, 18, 0);
    chk(take_cyc == 192 && got == 16'h8001, "R9", "parity word data", int'(got), 'h8001);
    chk(valid_cyc == 0, "R9", "valid with even parity", valid_cyc, 0);
  endtask

  task automatic t_jitter;
    run_word(1'b0, 16'hB3D9, 1'b1, -1, 1'b1, 18, 0);
    chk(got == 16'hB3D9, "R2", "data with jitter", int'(got), 'hB3D9);
    chk(min_iv == 10, "R2", "shortened cell", min_iv, 10);
    chk(max_iv == 14, "R2", "stretched cell", max_iv, 14);
    chk(valid_cyc == 12, "R2", "valid with jitter", valid_cyc, 12);
  endtask

  task automatic t_sync_tol;
    run_word(1'b1, 16'hC0DE, 1'b1, -1, 1'b0, 16, 0);
    chk(got == 16'hC0DE && valid_cyc == 12, "R3", "short sync accepted", int'(got), 'hC0DE);
    run_word(1'b1, 16'h3C5A, 1'b1, -1, 1'b0, 24, 0);
    chk(take_cyc == 0 && valid_cyc == 0, "R3", "long sync rejected", take_cyc, 0);
  endtask

  task automatic t_word_rst;
    run_word(1'b1, 16'h5A5A, 1'b1, -1, 1'b0, 18, 132);
    chk(valid_cyc == 0, "R10", "valid after word reset", valid_cyc, 0);
    chk(take_end == 1'b0 && take_cyc < 192, "R10", "take after word reset", take_cyc, 0);
    run_word(1'b0, 16'h7E81, 1'b1, -1, 1'b0, 18, 0);
    chk(got == 16'h7E81 && valid_cyc == 12, "R10", "word after word reset", int'(got), 'h7E81);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_shift_idle();
    t_cmd_pair();
    t_data_sync();
    t_single_wire();
    t_code_err();
    t_early_err();
    t_parity();
    t_jitter();
    t_sync_tol();
    t_word_rst();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule